// File: doc/BRIEF.md
# Low-Power Wake Controller

This block keeps track of the power state of a small 8-bit processor core. The core can be running, resting in IDLE, or parked in SLEEP. When the core executes its sleep instruction it pulses a request, and a mode select sampled with that pulse picks the target state. While the core rests, the block watches three wake sources: a timer overflow, a watchdog timeout and a change on an external wake port. When one of them fires, the block returns to run. From IDLE it tells the core to continue with the next instruction. From SLEEP it asks for a full chip reset.

The block holds its own watchdog, which is a free-running prescaler chained to a counter. It also holds a two-bit wake configuration register. That register turns the watchdog on (and with it the watchdog as a wake source) and arms the port-change wake. A timer wake from IDLE sets a sticky timer flag, which the core uses as bit 0 of its interrupt status. While the core runs, a watchdog timeout also requests a reset. The other wake inputs are ignored in run.

Top module: `wake_ctl`

## Requirements
- R1: After synchronous reset the state is run (`pwr_state_o` = 00), `resume_o`, `rst_req_o` and `tmr_flag_o` are 0, `osc_en_o` is 1, the configuration reads 00 and the watchdog is stopped and cleared.
- R2: A `slp_req_i` pulse in run moves the state, one clock later, to IDLE (01) when `slp_mode_i` is 0 or to SLEEP (10) when it is 1. `osc_en_o` is 0 only in SLEEP.
- R3: A timer overflow in IDLE returns the state to run one clock later. It gives a one-cycle `resume_o` pulse and sets `tmr_flag_o`.
- R4: A timer overflow in SLEEP is ignored: the state, `resume_o`, `rst_req_o` and `tmr_flag_o` do not change.
- R5: With configuration bit 0 set, the watchdog times out every 2^(PRE_W+CNT_W) clocks after it is enabled or cleared. A timeout wakes IDLE with a resume. With bit 0 clear it never times out and never wakes.
- R6: With configuration bit 1 set, any difference between `port_i` and the value latched at sleep entry wakes either low-power state. With bit 1 clear, port changes have no effect.
- R7: Any wake from SLEEP returns the state to run one clock later. It gives a single-cycle `rst_req_o` pulse and no `resume_o`.
- R8: A watchdog timeout while in run gives a single-cycle `rst_req_o` pulse, and the state stays run.
- R9: `wdt_clr_i` restarts the watchdog count and prescaler from zero, and it masks a timeout in the same cycle.
- R10: `tmr_flag_o` stays set until `flag_clr_i`. A set in the same cycle as a clear wins.
- R11: In run, timer overflows and port changes alter neither the state nor the timer flag.
- R12: A `slp_req_i` received while already in IDLE or SLEEP is ignored.
- R13: A `cfg_we_i` write loads `cfg_wdata_i`, and `wake_cfg_o` shows the written value from the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slp_req_i | input | 1 | Sleep instruction executed (pulse) |
| slp_mode_i | input | 1 | Target low-power state: 0 IDLE, 1 SLEEP |
| cfg_we_i | input | 1 | Write strobe for the wake configuration |
| cfg_wdata_i | input | 2 | bit0 watchdog enable, bit1 port wake enable |
| wdt_clr_i | input | 1 | Clear watchdog counter and prescaler |
| tmr_ovf_i | input | 1 | Timer overflow event |
| port_i | input | PORT_W | External wake port |
| flag_clr_i | input | 1 | Clear the timer wake flag |
| pwr_state_o | output | 2 | 00 run, 01 IDLE, 10 SLEEP |
| resume_o | output | 1 | Continue after the sleep instruction (pulse) |
| rst_req_o | output | 1 | Chip reset request (pulse) |
| tmr_flag_o | output | 1 | Timer wake flag, interrupt status bit 0 |
| osc_en_o | output | 1 | Oscillator enable |
| wake_cfg_o | output | 2 | Current wake configuration |

## Verification
A wrong state register shows on `pwr_state_o` and `osc_en_o` in the first cycle after the faulty edge. A mode swap or a wake routed the wrong way shows one clock after the wake as a `resume_o` where a `rst_req_o` belonged, or the reverse. A watchdog that counts wrongly, is not cleared, or runs while disabled is invisible until the timeout is due. It then shows as a reset or a wake that comes early, late or never, within one watchdog period. A bad port snapshot shows on the first port change, or the lack of one, after sleep entry.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'b00,
    PS_IDLE  = 2'b01,
    PS_SLEEP = 2'b10
  } pwr_e;

  localparam int CFG_W      = 2;
  localparam int CFG_WD_BIT = 0;
  localparam int CFG_PT_BIT = 1;
endpackage

// File: rtl/wake_wdog.sv
module wake_wdog #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic clr_i,
  output logic tmo_o
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pre_full;
  logic             cnt_full;

  assign pre_full = &pre_q;
  assign cnt_full = &cnt_q;
  assign tmo_o    = en_i && !clr_i && pre_full && cnt_full;

  always_ff @(posedge clk) begin
    if (rst || clr_i || !en_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (pre_full) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: a timeout wraps the whole chain back to zero
  p_wrap_after_tmo_r5: assert property (@(posedge clk) disable iff (rst)
    tmo_o |=> (pre_q == '0 && cnt_q == '0));

  // R9: a clear restarts the chain
  p_clear_restarts_r9: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (pre_q == '0 && cnt_q == '0 && !tmo_o));
endmodule

// File: rtl/wake_port_det.sv
module wake_port_det #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_i,
  input  logic              arm_i,
  input  logic [PORT_W-1:0] port_i,
  output logic              chg_o
);
  logic [PORT_W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst)            snap_q <= '0;
    else if (capture_i) snap_q <= port_i;
  end

  assign chg_o = arm_i && (port_i != snap_q);

  // R6: the reference value only moves on sleep entry
  p_snap_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !capture_i |=> $stable(snap_q));
endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic slp_req_i,
  input  logic slp_mode_i,
  input  logic tmr_ovf_i,
  input  logic wdt_tmo_i,
  input  logic port_chg_i,
  input  logic flag_clr_i,
  output pwr_e state_o,
  output logic resume_o,
  output logic rst_req_o,
  output logic tmr_flag_o,
  output logic capture_o
);
  pwr_e state_q;
  logic resume_q;
  logic rstreq_q;
  logic flag_q;

  assign capture_o = (state_q == PS_RUN) && slp_req_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PS_RUN;
      resume_q <= 1'b0;
      rstreq_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      resume_q <= 1'b0;
      rstreq_q <= 1'b0;
      unique case (state_q)
        PS_RUN: begin
          rstreq_q <= wdt_tmo_i;
          if (slp_req_i) state_q <= slp_mode_i ? PS_SLEEP : PS_IDLE;
        end
        PS_IDLE: begin
          if (tmr_ovf_i || wdt_tmo_i || port_chg_i) begin
            state_q  <= PS_RUN;
            resume_q <= 1'b1;
          end
        end
        PS_SLEEP: begin
          if (wdt_tmo_i || port_chg_i) begin
            state_q  <= PS_RUN;
            rstreq_q <= 1'b1;
          end
        end
        default: state_q <= PS_RUN;
      endcase
      if (state_q == PS_IDLE && tmr_ovf_i) flag_q <= 1'b1;
      else if (flag_clr_i)                 flag_q <= 1'b0;
    end
  end

  assign state_o    = state_q;
  assign resume_o   = resume_q;
  assign rst_req_o  = rstreq_q;
  assign tmr_flag_o = flag_q;

  // R3: timer wake from IDLE resumes and flags
  p_idle_timer_wake_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_IDLE && tmr_ovf_i) |=> (state_q == PS_RUN && resume_q && flag_q));

  // R3: resume is a single-cycle pulse
  p_resume_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    resume_q |=> !resume_q);

  // R4: timer overflow alone cannot leave SLEEP
  p_sleep_timer_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_SLEEP && tmr_ovf_i && !wdt_tmo_i && !port_chg_i) |=> (state_q == PS_SLEEP));

  // R7: leaving SLEEP always means a reset request, never a resume
  p_sleep_exit_reset_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_SLEEP) |=> (state_q != PS_RUN || (rstreq_q && !resume_q)));

  // R12: a second sleep request while resting keeps the state
  p_nested_sleep_r12: assert property (@(posedge clk) disable iff (rst)
    (state_q != PS_RUN && slp_req_i && !tmr_ovf_i && !wdt_tmo_i && !port_chg_i)
      |=> $stable(state_q));
endmodule

// File: rtl/wake_ctl.sv
module wake_ctl
  import wake_pkg::*;
#(
  parameter int PORT_W   = 8,
  parameter int WD_PRE_W = 8,
  parameter int WD_CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slp_req_i,
  input  logic              slp_mode_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_wdata_i,
  input  logic              wdt_clr_i,
  input  logic              tmr_ovf_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              flag_clr_i,
  output logic [1:0]        pwr_state_o,
  output logic              resume_o,
  output logic              rst_req_o,
  output logic              tmr_flag_o,
  output logic              osc_en_o,
  output logic [1:0]        wake_cfg_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             wdt_tmo;
  logic             port_chg;
  logic             capture;
  pwr_e             state;

  always_ff @(posedge clk) begin
    if (rst)           cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_wdata_i;
  end

  wake_wdog #(.PRE_W(WD_PRE_W), .CNT_W(WD_CNT_W)) u_wdog (
    .clk   (clk),
    .rst   (rst),
    .en_i  (cfg_q[CFG_WD_BIT]),
    .clr_i (wdt_clr_i),
    .tmo_o (wdt_tmo)
  );

  wake_port_det #(.PORT_W(PORT_W)) u_port (
    .clk       (clk),
    .rst       (rst),
    .capture_i (capture),
    .arm_i     (cfg_q[CFG_PT_BIT]),
    .port_i    (port_i),
    .chg_o     (port_chg)
  );

  wake_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .slp_req_i  (slp_req_i),
    .slp_mode_i (slp_mode_i),
    .tmr_ovf_i  (tmr_ovf_i),
    .wdt_tmo_i  (wdt_tmo),
    .port_chg_i (port_chg),
    .flag_clr_i (flag_clr_i),
    .state_o    (state),
    .resume_o   (resume_o),
    .rst_req_o  (rst_req_o),
    .tmr_flag_o (tmr_flag_o),
    .capture_o  (capture)
  );

  assign pwr_state_o = state;
  assign osc_en_o    = (state != PS_SLEEP);
  assign wake_cfg_o  = cfg_q;

  // R5: a disabled watchdog never produces a timeout
  p_wd_off_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !cfg_q[CFG_WD_BIT] |-> !wdt_tmo);

  // R11: run-mode timer overflow leaves the flag alone
  p_run_flag_kept_r11: assert property (@(posedge clk) disable iff (rst)
    (state == PS_RUN && !flag_clr_i) |=> $stable(tmr_flag_o));
endmodule

// File: tb/wake_ctl_bench.sv
`timescale 1ns/1ps
module wake_ctl_bench;
  localparam int PW   = 8;
  localparam int PREW = 2;
  localparam int CNTW = 3;
  localparam int WMAX = (1 << (PREW + CNTW)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slp_req = 0, slp_mode = 0, cfg_we = 0, wdt_clr = 0, tmr_ovf = 0, flag_clr = 0;
  logic [1:0] cfg_wdata = 0;
  logic [PW-1:0] port = 0;
  logic [1:0] st_o, cfg_o;
  logic res_o, rrq_o, flg_o, osc_o;

  always #2.5 clk = ~clk;

  wake_ctl #(.PORT_W(PW), .WD_PRE_W(PREW), .WD_CNT_W(CNTW)) u_wake_ctl (
    .clk(clk), .rst(rst), .slp_req_i(slp_req), .slp_mode_i(slp_mode),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .wdt_clr_i(wdt_clr),
    .tmr_ovf_i(tmr_ovf), .port_i(port), .flag_clr_i(flag_clr),
    .pwr_state_o(st_o), .resume_o(res_o), .rst_req_o(rrq_o),
    .tmr_flag_o(flg_o), .osc_en_o(osc_o), .wake_cfg_o(cfg_o)
  );

  int vectors = 0;
  int fails = 0;
  string phase = "R1";

  // behavioural reference model
  int m_st = 0, m_wc = 0;
  bit m_res = 0, m_rrq = 0, m_flag = 0, m_wden = 0, m_pen = 0;
  logic [PW-1:0] m_snap = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_wc = 0; m_res = 0; m_rrq = 0; m_flag = 0;
      m_wden = 0; m_pen = 0; m_snap = 0;
    end else begin
      bit tmo, pchg;
      int nst;
      tmo  = m_wden && !wdt_clr && (m_wc == WMAX);
      pchg = m_pen && (port != m_snap);
      nst = m_st; m_res = 0; m_rrq = 0;
      if (m_st == 0) begin
        m_rrq = tmo;
        if (slp_req) begin nst = slp_mode ? 2 : 1; m_snap = port; end
      end else if (m_st == 1) begin
        if (tmr_ovf || tmo || pchg) begin nst = 0; m_res = 1; end
      end else begin
        if (tmo || pchg) begin nst = 0; m_rrq = 1; end
      end
      if (m_st == 1 && tmr_ovf) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (wdt_clr || !m_wden) m_wc = 0; else m_wc = (m_wc + 1) % (WMAX + 1);
      if (cfg_we) begin m_wden = cfg_wdata[0]; m_pen = cfg_wdata[1]; end
      m_st = nst;
    end
  end

  task automatic chk(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk({phase, " state"},  st_o,  m_st);
      chk({phase, " resume"}, res_o, m_res);
      chk({phase, " rstreq"}, rrq_o, m_rrq);
      chk({phase, " flag"},   flg_o, m_flag);
      chk({phase, " osc"},    osc_o, (m_st != 2));
      chk({phase, " cfg"},    cfg_o, {m_pen, m_wden});
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter(bit mode);
    slp_mode = mode; slp_req = 1; tick(1); slp_req = 0; slp_mode = 0;
  endtask

  task automatic write_cfg(logic [1:0] v);
    cfg_wdata = v; cfg_we = 1; tick(1); cfg_we = 0;
  endtask

  task automatic pulse_tmr();
    tmr_ovf = 1; tick(1); tmr_ovf = 0;
  endtask

  initial begin
    int cnt;
    tick(3); rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", st_o, 0); chk("R1 osc", osc_o, 1); chk("R1 flags", {res_o, rrq_o, flg_o}, 0);
    chk("R1 cfg", cfg_o, 0);

    // R2 / R3: IDLE entry and timer wake
    phase = "R2"; enter(0); chk("R2 idle", st_o, 1); chk("R2 osc idle", osc_o, 1);
    tick(3); phase = "R3"; pulse_tmr();
    chk("R3 state", st_o, 0); chk("R3 resume", res_o, 1); chk("R3 flag", flg_o, 1);
    tick(1); chk("R3 pulse end", res_o, 0);

    // R10 flag sticky, set beats clear
    phase = "R10"; tick(4); chk("R10 sticky", flg_o, 1);
    flag_clr = 1; tick(1); flag_clr = 0; chk("R10 cleared", flg_o, 0);
    enter(0); tmr_ovf = 1; flag_clr = 1; tick(1); tmr_ovf = 0; flag_clr = 0;
    chk("R10 set wins", flg_o, 1);
    flag_clr = 1; tick(1); flag_clr = 0;

    // R13 config write, R4 timer ignored in SLEEP, R6/R7 port wake from SLEEP
    phase = "R13"; port = 8'h5A; write_cfg(2'b10); chk("R13 readback", cfg_o, 2);
    phase = "R4"; enter(1); chk("R2 sleep", st_o, 2); chk("R2 osc sleep", osc_o, 0);
    pulse_tmr(); chk("R4 stay", st_o, 2); chk("R4 no flag", flg_o, 0); chk("R4 no resume", res_o, 0);
    tick(2); phase = "R7"; port = 8'h5B; tick(1);
    chk("R7 state", st_o, 0); chk("R7 rstreq", rrq_o, 1); chk("R7 no resume", res_o, 0);
    tick(1); chk("R7 single pulse", rrq_o, 0);

    // R11 run-mode sources ignored
    phase = "R11"; port = 8'h00; pulse_tmr(); port = 8'hFF; tick(2);
    chk("R11 state", st_o, 0); chk("R11 flag", flg_o, 0);

    // R6 port wake from IDLE, and disabled port wake
    phase = "R6"; enter(0); port = 8'h0F; tick(1);
    chk("R6 idle wake", st_o, 0); chk("R6 resume", res_o, 1);
    write_cfg(2'b00); enter(0); port = 8'hAA; tick(4); chk("R6 disarmed", st_o, 1);

    // R12 nested sleep request ignored
    phase = "R12"; enter(1); chk("R12 stays idle", st_o, 1); pulse_tmr(); tick(1);
    flag_clr = 1; tick(1); flag_clr = 0;

    // R8 run-mode watchdog reset
    phase = "R8"; write_cfg(2'b01); cnt = 0;
    for (int i = 0; i < WMAX + 2; i++) begin if (rrq_o) cnt++; tick(1); end
    chk("R8 one reset pulse", cnt, 1); chk("R8 still run", st_o, 0);

    // R9 periodic clear keeps the watchdog quiet
    phase = "R9"; cnt = 0;
    for (int i = 0; i < 4 * (WMAX + 1); i++) begin
      wdt_clr = (i % 10 == 0); tick(1); if (rrq_o) cnt++;
    end
    wdt_clr = 0; chk("R9 no timeout", cnt, 0);

    // R5 watchdog wake from IDLE, R7 from SLEEP
    phase = "R5"; wdt_clr = 1; enter(0); wdt_clr = 0; cnt = 0;
    for (int i = 0; i < WMAX + 2; i++) begin if (res_o) cnt++; tick(1); end
    chk("R5 wd wake resume", cnt, 1);
    phase = "R7"; wdt_clr = 1; enter(1); wdt_clr = 0; cnt = 0;
    for (int i = 0; i < WMAX + 2; i++) begin if (rrq_o) cnt++; tick(1); end
    chk("R7 wd wake reset", cnt, 1); chk("R7 back to run", st_o, 0);
    phase = "R5"; write_cfg(2'b00); enter(0); tick(3 * (WMAX + 1));
    chk("R5 disabled no wake", st_o, 1); pulse_tmr();

    // mixed stimulus against the model
    phase = "R2";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 100;
      slp_req  = (r < 6); slp_mode = $urandom % 2;
      tmr_ovf  = ($urandom % 100) < 4;
      flag_clr = ($urandom % 100) < 5;
      wdt_clr  = ($urandom % 100) < 2;
      cfg_we   = ($urandom % 100) < 2; cfg_wdata = $urandom % 4;
      if (($urandom % 100) < 5) port = $urandom % 256;
      tick(1);
    end
    {slp_req, tmr_ovf, flag_clr, wdt_clr, cfg_we} = 0;
    tick(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    fails++;
    $display("FAIL watchdog: bench hung, got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule